// File: doc/BRIEF.md
# Load Lane Extractor and Store Lane Steerer

This block is the data-side alignment stage between a 64-bit data memory and the register writeback path. On a load it takes the aligned memory word that was read, the low three bits of the effective address and a load-kind code. It picks the byte, halfword, word or doubleword at that lane and widens the value to 64 bits by zero or sign extension. A destination-width input chooses whether a signed narrow value is widened to 32 or to 64 bits. A flag tells writeback to use the 32-bit register form.

On a store, the same kind code and address offset yield one byte-enable bit per lane. The store data is copied into every lane group of the access width, so the enabled lanes carry the right bytes whatever the offset. An offset that is not a multiple of the access width is flagged as an alignment error. Accesses that would cross a 64-bit boundary are never formed by the block. All results are registered once, so outputs appear one clock after the request.

Top module: `lsx_top`

## Requirements
- R1: While reset is asserted, and in any cycle after a cycle with `in_valid` low, every output is zero. Otherwise outputs reflect the request one clock after it was presented, and `out_valid` follows `in_valid` with one cycle of delay.
- R2: `in_kind[1:0]` is the log2 of the access size in bytes (0 byte, 1 halfword, 2 word, 3 doubleword) and `in_kind[2]` marks a signed load. Code 3'b111 behaves exactly like code 3'b011.
- R3: The memory word is little-endian, and `in_addr_lo` is the lowest byte lane of the access. A doubleword load returns the memory word unchanged.
- R4: Unsigned byte, halfword and word loads (codes 0, 1, 2) zero-extend the selected value to 64 bits.
- R5: Signed byte and halfword loads (codes 4, 5) sign-extend to 64 bits when `in_dst32` is 0. When `in_dst32` is 1 they sign-extend to 32 bits and bits 63:32 are zero.
- R6: A signed word load (code 6) sign-extends the selected 32-bit value to 64 bits whatever `in_dst32` is.
- R7: For loads of codes 0, 1, 2, 4 and 5, `out_w32` equals `in_dst32`. For codes 3, 6 and 7, and for stores, it is 0.
- R8: An aligned store of N bytes sets exactly N consecutive bits of `out_wstrb`, starting at bit `in_addr_lo`. A load leaves `out_wstrb` at zero.
- R9: An aligned store puts the low N bytes of `in_wdata` into every N-byte lane group of `out_wdata`. Byte lane i carries source byte i mod N.
- R10: `out_misalign` is 1 when `in_addr_lo` is not a multiple of N. In that case `out_ldata`, `out_wstrb`, `out_wdata` and `out_w32` are all zero.
- R11: A load drives `out_wdata` to zero. A store drives `out_ldata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_store | input | 1 | 1 for store, 0 for load |
| in_kind | input | 3 | Access kind: size log2 in [1:0], signed in [2] |
| in_dst32 | input | 1 | Destination register is 32-bit form |
| in_addr_lo | input | 3 | Byte offset of the access inside the word |
| in_rdata | input | 64 | Aligned word read from memory |
| in_wdata | input | 64 | Store data, value in low bytes |
| out_valid | output | 1 | Registered result valid |
| out_ldata | output | 64 | Extended load value |
| out_w32 | output | 1 | Write back in 32-bit form |
| out_wstrb | output | 8 | Store byte enables, one per lane |
| out_wdata | output | 64 | Store data steered into lanes |
| out_misalign | output | 1 | Offset not a multiple of access width |

## Verification
The bench goes after the top lane (offset 7) with a set sign bit. There, a design that shifts the wrong way or sign-extends from the wrong bit returns a wrong or positive value. It also covers signed narrow loads into 32-bit destinations, where a design that extends all the way to 64 bits leaves ones in the upper half. It checks the signed word load with a 32-bit destination request, which must still extend to 64 bits, and the alias kind code 7. Misaligned halfword, word and doubleword offsets must give a raised flag with no strobes. A strobe generator that is off by one lane, or that fails to replicate narrow data, shows up as a wrong byte-enable or data pattern on stores at offsets 4 and 6.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    typedef enum logic [2:0] {
        LK_UBYTE  = 3'd0,
        LK_UHALF  = 3'd1,
        LK_UWORD  = 3'd2,
        LK_DWORD  = 3'd3,
        LK_SBYTE  = 3'd4,
        LK_SHALF  = 3'd5,
        LK_SWORD  = 3'd6,
        LK_SDWORD = 3'd7
    } lsx_kind_e;

    localparam int unsigned LSX_SIZE_W = 2;

endpackage

// File: rtl/lsx_align_chk.sv
module lsx_align_chk #(
    parameter int unsigned OFF_W = 3
) (
    input  logic [1:0]       size_log2,
    input  logic [OFF_W-1:0] offset,
    output logic             misaligned
);
    logic [OFF_W-1:0] low_mask;

    always_comb begin
        low_mask   = OFF_W'((32'd1 << size_log2) - 32'd1);
        misaligned = (offset & low_mask) != '0;
    end
endmodule

// File: rtl/lsx_load_extract.sv
module lsx_load_extract
    import lsx_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned OFF_W  = 3
) (
    input  lsx_kind_e         kind,
    input  logic              dst32,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] value,
    output logic              w32
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] shifted;
    logic [7:0]        b;
    logic [15:0]       h;
    logic [HALF_W-1:0] w;

    always_comb begin
        shifted = rdata >> {offset, 3'b000};
        b       = shifted[7:0];
        h       = shifted[15:0];
        w       = shifted[HALF_W-1:0];
        value   = '0;
        w32     = 1'b0;
        unique case (kind)
            LK_UBYTE: begin
                value = {{(DATA_W-8){1'b0}}, b};
                w32   = dst32;
            end
            LK_UHALF: begin
                value = {{(DATA_W-16){1'b0}}, h};
                w32   = dst32;
            end
            LK_UWORD: begin
                value = {{HALF_W{1'b0}}, w};
                w32   = dst32;
            end
            LK_SBYTE: begin
                if (dst32)
                    value = {{HALF_W{1'b0}}, {(HALF_W-8){b[7]}}, b};
                else
                    value = {{(DATA_W-8){b[7]}}, b};
                w32 = dst32;
            end
            LK_SHALF: begin
                if (dst32)
                    value = {{HALF_W{1'b0}}, {(HALF_W-16){h[15]}}, h};
                else
                    value = {{(DATA_W-16){h[15]}}, h};
                w32 = dst32;
            end
            LK_SWORD: begin
                value = {{HALF_W{w[HALF_W-1]}}, w};
                w32   = 1'b0;
            end
            LK_DWORD, LK_SDWORD: begin
                value = shifted;
                w32   = 1'b0;
            end
            default: begin
                value = '0;
                w32   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lsx_store_lanes.sv
module lsx_store_lanes #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned OFF_W  = 3
) (
    input  logic [1:0]          size_log2,
    input  logic [OFF_W-1:0]    offset,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] strb,
    output logic [DATA_W-1:0]   lanes
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [OFF_W:0]   first;
    logic [OFF_W:0]   past_end;
    logic [OFF_W-1:0] wrap_mask;

    always_comb begin
        first     = {1'b0, offset};
        past_end  = first + (OFF_W+1)'(32'd1 << size_log2);
        wrap_mask = OFF_W'((32'd1 << size_log2) - 32'd1);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] src;
        always_comb begin
            strb[i] = ((OFF_W+1)'(i) >= first) && ((OFF_W+1)'(i) < past_end);
            src     = OFF_W'(i) & wrap_mask;
            lanes[i*8 +: 8] = wdata[{src, 3'b000} +: 8];
        end
    end
endmodule

// File: rtl/lsx_top.sv
module lsx_top
    import lsx_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_store,
    input  logic [2:0]        in_kind,
    input  logic              in_dst32,
    input  logic [OFF_W-1:0]  in_addr_lo,
    input  logic [DATA_W-1:0] in_rdata,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_ldata,
    output logic              out_w32,
    output logic [LANES-1:0]  out_wstrb,
    output logic [DATA_W-1:0] out_wdata,
    output logic              out_misalign
);
    lsx_kind_e         kind;
    logic [1:0]        size_log2;
    logic              mis;
    logic [DATA_W-1:0] ld_val;
    logic              ld_w32;
    logic [LANES-1:0]  st_strb;
    logic [DATA_W-1:0] st_lanes;

    logic              n_valid;
    logic [DATA_W-1:0] n_ldata;
    logic              n_w32;
    logic [LANES-1:0]  n_wstrb;
    logic [DATA_W-1:0] n_wdata;
    logic              n_mis;

    assign kind      = lsx_kind_e'(in_kind);
    assign size_log2 = in_kind[1:0];

    lsx_align_chk #(.OFF_W(OFF_W)) u_align (
        .size_log2  (size_log2),
        .offset     (in_addr_lo),
        .misaligned (mis)
    );

    lsx_load_extract #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_load (
        .kind   (kind),
        .dst32  (in_dst32),
        .offset (in_addr_lo),
        .rdata  (in_rdata),
        .value  (ld_val),
        .w32    (ld_w32)
    );

    lsx_store_lanes #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_store (
        .size_log2 (size_log2),
        .offset    (in_addr_lo),
        .wdata     (in_wdata),
        .strb      (st_strb),
        .lanes     (st_lanes)
    );

    always_comb begin
        n_valid = in_valid;
        n_ldata = '0;
        n_w32   = 1'b0;
        n_wstrb = '0;
        n_wdata = '0;
        n_mis   = 1'b0;
        if (in_valid) begin
            n_mis = mis;
            if (!mis) begin
                if (in_store) begin
                    n_wstrb = st_strb;
                    n_wdata = st_lanes;
                end else begin
                    n_ldata = ld_val;
                    n_w32   = ld_w32;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_ldata    <= '0;
            out_w32      <= 1'b0;
            out_wstrb    <= '0;
            out_wdata    <= '0;
            out_misalign <= 1'b0;
        end else begin
            out_valid    <= n_valid;
            out_ldata    <= n_ldata;
            out_w32      <= n_w32;
            out_wstrb    <= n_wstrb;
            out_wdata    <= n_wdata;
            out_misalign <= n_mis;
        end
    end
endmodule

// File: rtl/lsx_chk.sv
module lsx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_store,
    input logic [2:0]  in_kind,
    input logic        in_dst32,
    input logic [2:0]  in_addr_lo,
    input logic        out_valid,
    input logic [63:0] out_ldata,
    input logic        out_w32,
    input logic [7:0]  out_wstrb,
    input logic [63:0] out_wdata,
    input logic        out_misalign
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_ldata == 64'd0 && out_wstrb == 8'd0 && out_wdata == 64'd0 && !out_misalign)); // R1

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_UBYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_store && in_kind == 3'd0) |=> (out_ldata[63:8] == 56'd0)); // R4

    AST_SWORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_store && in_kind == 3'd6) |=> !out_w32); // R7

    AST_W32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_w32 |-> (out_ldata[63:32] == 32'd0)); // R5

    AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_store) |=> (out_wstrb == 8'd0 && out_wdata == 64'd0)); // R8

    AST_BYTE_STORE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_store && in_kind[1:0] == 2'd0) |=> ($countones(out_wstrb) == 1)); // R8

    AST_DWORD_ODD_MIS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind[1:0] == 2'd3 && in_addr_lo != 3'd0) |=> out_misalign); // R10

    AST_MIS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_misalign |-> (out_wstrb == 8'd0 && out_ldata == 64'd0 && !out_w32)); // R10

    AST_STORE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_store) |=> (out_ldata == 64'd0)); // R11
endmodule

bind lsx_top lsx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_store     (in_store),
    .in_kind      (in_kind),
    .in_dst32     (in_dst32),
    .in_addr_lo   (in_addr_lo),
    .out_valid    (out_valid),
    .out_ldata    (out_ldata),
    .out_w32      (out_w32),
    .out_wstrb    (out_wstrb),
    .out_wdata    (out_wdata),
    .out_misalign (out_misalign)
);

// File: tb/sim_lsx_top.sv
`timescale 1ns/1ps
module sim_lsx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_store = 1'b0;
    logic [2:0]  in_kind = 3'd0;
    logic        in_dst32 = 1'b0;
    logic [2:0]  in_addr_lo = 3'd0;
    logic [63:0] in_rdata = 64'd0;
    logic [63:0] in_wdata = 64'd0;
    logic        out_valid;
    logic [63:0] out_ldata;
    logic        out_w32;
    logic [7:0]  out_wstrb;
    logic [63:0] out_wdata;
    logic        out_misalign;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lsx_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_store(in_store),
        .in_kind(in_kind), .in_dst32(in_dst32), .in_addr_lo(in_addr_lo),
        .in_rdata(in_rdata), .in_wdata(in_wdata), .out_valid(out_valid),
        .out_ldata(out_ldata), .out_w32(out_w32), .out_wstrb(out_wstrb),
        .out_wdata(out_wdata), .out_misalign(out_misalign)
    );

    function automatic bit e_mis(logic [2:0] k, logic [2:0] off);
        int n = 1 << k[1:0];
        return (int'(off) % n) != 0;
    endfunction

    function automatic logic [63:0] e_ld(logic [2:0] k, logic d32, logic [2:0] off, logic [63:0] rd);
        logic [63:0] s = rd >> (8 * int'(off));
        logic [63:0] r;
        case (k)
            3'd0: r = {56'd0, s[7:0]};
            3'd1: r = {48'd0, s[15:0]};
            3'd2: r = {32'd0, s[31:0]};
            3'd4: r = d32 ? {32'd0, {24{s[7]}}, s[7:0]}  : {{56{s[7]}}, s[7:0]};
            3'd5: r = d32 ? {32'd0, {16{s[15]}}, s[15:0]} : {{48{s[15]}}, s[15:0]};
            3'd6: r = {{32{s[31]}}, s[31:0]};
            default: r = s;
        endcase
        return r;
    endfunction

    function automatic logic e_w32(logic [2:0] k, logic d32);
        return d32 && (k == 3'd0 || k == 3'd1 || k == 3'd2 || k == 3'd4 || k == 3'd5);
    endfunction

    function automatic logic [7:0] e_strb(logic [2:0] k, logic [2:0] off);
        int n = 1 << k[1:0];
        logic [7:0] r = 8'd0;
        for (int i = 0; i < 8; i++) if (i >= int'(off) && i < int'(off) + n) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [63:0] e_wd(logic [2:0] k, logic [63:0] wd);
        int n = 1 << k[1:0];
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = wd[(i % n)*8 +: 8];
        return r;
    endfunction

    function automatic string ld_tag(logic [2:0] k);
        case (k)
            3'd0, 3'd1, 3'd2: return "R4";
            3'd4, 3'd5:       return "R5";
            3'd6:             return "R6";
            3'd7:             return "R2";
            default:          return "R3";
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic v, logic st, logic [2:0] k, logic d32, logic [2:0] off,
                         logic [63:0] rd, logic [63:0] wd);
        bit m;
        in_valid = v; in_store = st; in_kind = k; in_dst32 = d32;
        in_addr_lo = off; in_rdata = rd; in_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        m = e_mis(k, off);
        chk("R1 valid", {63'd0, out_valid}, {63'd0, v});
        if (!v) begin
            chk("R1 idle ldata", out_ldata, 64'd0);
            chk("R1 idle wstrb", {56'd0, out_wstrb}, 64'd0);
        end else begin
            chk("R10 misalign", {63'd0, out_misalign}, {63'd0, m});
            if (m) begin
                chk("R10 ldata", out_ldata, 64'd0);
                chk("R10 wstrb", {56'd0, out_wstrb}, 64'd0);
                chk("R10 w32", {63'd0, out_w32}, 64'd0);
            end else if (st) begin
                chk("R8 wstrb", {56'd0, out_wstrb}, {56'd0, e_strb(k, off)});
                chk("R9 wdata", out_wdata, e_wd(k, wd));
                chk("R11 ldata", out_ldata, 64'd0);
                chk("R7 w32 store", {63'd0, out_w32}, 64'd0);
            end else begin
                chk(ld_tag(k), out_ldata, e_ld(k, d32, off, rd));
                chk("R7 w32", {63'd0, out_w32}, {63'd0, e_w32(k, d32)});
                chk("R11 wdata", out_wdata, 64'd0);
                chk("R8 load wstrb", {56'd0, out_wstrb}, 64'd0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        logic [63:0] pat;
        seed_sink = $urandom(32'h5eed_1234);
        pat = 64'h8877_6655_4433_2211;
        repeat (3) @(negedge clk);
        chk("R1 reset ldata", out_ldata, 64'd0);
        chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        // R3 doubleword and little-endian lanes
        apply(1, 0, 3'd3, 0, 3'd0, pat, 0);
        apply(1, 0, 3'd0, 0, 3'd5, pat, 0);
        // R5 top lane with sign bit, both destination widths
        apply(1, 0, 3'd4, 0, 3'd7, pat, 0);
        apply(1, 0, 3'd4, 1, 3'd7, pat, 0);
        apply(1, 0, 3'd5, 1, 3'd6, 64'h8000_0000_0000_0000, 0);
        // R6 signed word ignores 32-bit destination request
        apply(1, 0, 3'd6, 1, 3'd4, 64'hF000_0001_0000_0000, 0);
        // R2 code 7 aliases doubleword
        apply(1, 0, 3'd7, 1, 3'd0, pat, 0);
        apply(1, 0, 3'd7, 0, 3'd4, pat, 0);
        // R10 misaligned kinds
        apply(1, 0, 3'd5, 0, 3'd1, pat, 0);
        apply(1, 1, 3'd2, 0, 3'd2, 0, pat);
        // R8 R9 stores at offsets 4 and 6
        apply(1, 1, 3'd2, 0, 3'd4, 0, pat);
        apply(1, 1, 3'd1, 0, 3'd6, 0, pat);
        apply(1, 1, 3'd0, 0, 3'd3, 0, pat);
        // R1 idle cycle
        apply(0, 1, 3'd0, 0, 3'd0, pat, pat);

        for (int it = 0; it < 600; it++) begin
            logic [63:0] rd, wd;
            logic [2:0]  k, off;
            rd  = {$urandom, $urandom};
            wd  = {$urandom, $urandom};
            k   = 3'($urandom);
            off = 3'($urandom);
            if ($urandom % 3 != 0) off = off & ~3'(((1 << k[1:0]) - 1));
            apply(($urandom % 8) != 0, 1'($urandom), k, 1'($urandom), off, rd, wd);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule